// File: doc/BRIEF.md
# Folded Thermometer-to-Binary Decoder

This block is the digital back end of a 6-bit flash converter. It takes the 63 comparator outputs as a thermometer code and returns a 6-bit binary word. It does this with two sub-decoders, each about the square root of a single full-width decoder. The coarse path counts the ones on seven tap comparators, one at the top of each group of eight. That count gives the upper three bits and also names the segment of seven fine comparators that holds the transition. The fine path counts the ones in that segment to give the lower three bits.

Each fine segment has its own small counter. A correction adder then takes the counts of the segments that were not selected and adds how far each one departs from its clean value: all ones below the selected segment, all zeros above it. For a clean code this residue is zero. With bubbles, the residue pulls the result back to the total ones-count of the input. The output error is therefore never larger than the number of flipped comparators.

The input code is registered, and the result is registered again, so one conversion is accepted on every clock.

Top module: `fold_therm_dec`

## Requirements
- R1: A code present at `therm_i` before rising edge n appears on `bin_o` after rising edge n+1, and not after edge n alone.
- R2: While `rst_ni` is low, `bin_o` is 0, and asserting `rst_ni` clears it at once without waiting for a clock edge.
- R3: For every clean thermometer code with value v (bits 0..v-1 set, the rest clear, v from 0 to 63), `bin_o` equals v.
- R4: For a clean code, `bin_o[5:3]` equals the number of set bits among the tap comparators at indices 7, 15, 23, 31, 39, 47 and 55.
- R5: An all-zero input gives 0 and an all-one input gives 63.
- R6: For a clean code of value v with b comparators flipped, |`bin_o` - v| is at most b.
- R7: Codes presented on consecutive cycles give independent results on consecutive cycles, one conversion per clock, with no idle cycles between them.
- R8: For any 63-bit input, clean or not, `bin_o` equals the number of set bits in that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| therm_i | input | 63 | Comparator outputs, bit i high when the input is above threshold i |
| bin_o | output | 6 | Registered binary result |

## Verification
The assertions check several things on every cycle. Each registered result must equal the ones-count of the code captured one edge earlier. For any clean captured code, the coarse count must point at the segment that holds the transition, and the correction residue must be zero. The all-zero and all-one inputs must give the two extreme values. Only the bench scenarios show the bubble error bound against the intended clean value, the exact two-edge latency, and the asynchronous clear in the middle of a run. They also sweep all 64 clean codes back to back, which shows that consecutive conversions do not interfere.

// File: rtl/fold_dec_pkg.sv
package fold_dec_pkg;
  localparam int unsigned POP_W = 256;

  function automatic int unsigned pop_cnt(input logic [POP_W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < POP_W; i++) begin
      if (v[i]) n++;
    end
    return n;
  endfunction
endpackage

// File: rtl/fold_coarse_dec.sv
module fold_coarse_dec
  import fold_dec_pkg::*;
#(
  parameter int unsigned CW = 3,
  parameter int unsigned FW = 3,
  localparam int unsigned OW = CW + FW,
  localparam int unsigned N  = (1 << OW) - 1
) (
  input  logic [N-1:0]  therm_i,
  output logic [CW-1:0] seg_o
);
  localparam int unsigned SEG = 1 << FW;
  localparam int unsigned NT  = (1 << CW) - 1;

  logic [NT-1:0] taps;

  // top comparator of each segment forms the coarse thermometer
  for (genvar gi = 0; gi < NT; gi++) begin : g_tap
    assign taps[gi] = therm_i[(gi+1)*SEG-1];
  end

  assign seg_o = CW'(pop_cnt(POP_W'(taps)));
endmodule

// File: rtl/fold_seg_cnt.sv
module fold_seg_cnt
  import fold_dec_pkg::*;
#(
  parameter int unsigned FW = 3,
  localparam int unsigned NF = (1 << FW) - 1
) (
  input  logic [NF-1:0] seg_i,
  output logic [FW-1:0] cnt_o
);
  assign cnt_o = FW'(pop_cnt(POP_W'(seg_i)));
endmodule

// File: rtl/fold_fine_sel.sv
module fold_fine_sel #(
  parameter int unsigned CW = 3,
  parameter int unsigned FW = 3,
  localparam int unsigned NSEG = 1 << CW,
  localparam int unsigned RW   = CW + FW + 2
) (
  input  logic [NSEG-1:0][FW-1:0] cnt_i,
  input  logic [CW-1:0]           sel_i,
  output logic [FW-1:0]           fine_o,
  output logic signed [RW-1:0]    resid_o
);
  localparam int unsigned NF = (1 << FW) - 1;

  logic signed [RW-1:0] acc;

  always_comb begin
    fine_o = cnt_i[sel_i];
    acc    = '0;
    // distance of every other segment from its clean value
    for (int k = 0; k < int'(NSEG); k++) begin
      if (k > int'(sel_i)) begin
        acc = acc + signed'(RW'(cnt_i[k]));
      end else if (k < int'(sel_i)) begin
        acc = acc - signed'(RW'(NF)) + signed'(RW'(cnt_i[k]));
      end
    end
    resid_o = acc;
  end
endmodule

// File: rtl/fold_therm_dec.sv
module fold_therm_dec
  import fold_dec_pkg::*;
#(
  parameter int unsigned CW = 3,
  parameter int unsigned FW = 3,
  localparam int unsigned OW = CW + FW,
  localparam int unsigned N  = (1 << OW) - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  therm_i,
  output logic [OW-1:0] bin_o
);
  localparam int unsigned SEG  = 1 << FW;
  localparam int unsigned NF   = SEG - 1;
  localparam int unsigned NSEG = 1 << CW;
  localparam int unsigned RW   = OW + 2;

  logic [N-1:0]              therm_q;
  logic [OW-1:0]             bin_q;
  logic [CW-1:0]             seg_sel;
  logic [NSEG-1:0][FW-1:0]   seg_cnt;
  logic [FW-1:0]             fine;
  logic signed [RW-1:0]      resid;
  logic signed [RW-1:0]      sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) therm_q <= '0;
    else         therm_q <= therm_i;
  end

  fold_coarse_dec #(.CW(CW), .FW(FW)) u_coarse (
    .therm_i (therm_q),
    .seg_o   (seg_sel)
  );

  for (genvar gs = 0; gs < NSEG; gs++) begin : g_seg
    fold_seg_cnt #(.FW(FW)) u_cnt (
      .seg_i (therm_q[gs*SEG +: NF]),
      .cnt_o (seg_cnt[gs])
    );
  end

  fold_fine_sel #(.CW(CW), .FW(FW)) u_fine (
    .cnt_i   (seg_cnt),
    .sel_i   (seg_sel),
    .fine_o  (fine),
    .resid_o (resid)
  );

  // coarse/fine word plus bubble correction
  assign sum = signed'(RW'({seg_sel, fine})) + resid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bin_q <= '0;
    else         bin_q <= sum[OW-1:0];
  end

  assign bin_o = bin_q;

  // checks
  logic          q_clean;
  logic [OW-1:0] lo_idx, hi_idx;
  assign q_clean = ((therm_q & (therm_q + 1'b1)) == '0);
  assign lo_idx  = {seg_sel, {FW{1'b0}}} - 1'b1;
  assign hi_idx  = {seg_sel, {FW{1'b1}}};

  p_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (int'(bin_o) == int'(pop_cnt(POP_W'($past(therm_q))))));

  p_clean_tap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_clean |-> (((seg_sel == '0) || therm_q[lo_idx]) &&
                 ((seg_sel == CW'(NSEG-1)) || !therm_q[hi_idx])));

  p_clean_resid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_clean |-> (resid == '0));

  p_all_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_q == '1) |=> (bin_o == OW'(N)));

  p_all_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_q == '0) |=> (bin_o == '0));
endmodule

// File: tb/fold_therm_dec_test.sv
module fold_therm_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [62:0] therm = '0;
  logic [5:0]  bin;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  bit    q_v[2];
  bit    q_cl[2];
  int    q_ref[2];
  int    q_nb[2];
  int    q_pop[2];
  int    q_tap[2];
  string q_tag[2];

  fold_therm_dec uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .therm_i (therm),
    .bin_o   (bin)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      total++; bad++;
      $display("FAIL R7 watchdog act=%0d exp=%0d", cyc, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [62:0] therm_of(input int v);
    logic [62:0] t;
    for (int i = 0; i < 63; i++) t[i] = (i < v);
    return t;
  endfunction

  function automatic int tap_cnt(input logic [62:0] d);
    int n = 0;
    for (int i = 1; i <= 7; i++) if (d[i*8-1]) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive at negedge; result checked two negedges later
  task automatic drive(input logic [62:0] d, input int ref_v, input bit clean, input string tag);
    int err;
    @(negedge clk);
    if (q_v[1]) begin
      if (q_cl[1]) begin
        chk(int'(bin) == q_ref[1], q_tag[1], int'(bin), q_ref[1]);
        chk(int'(bin[5:3]) == q_tap[1], "R4", int'(bin[5:3]), q_tap[1]);
      end else begin
        err = int'(bin) - q_ref[1];
        if (err < 0) err = -err;
        chk(err <= q_nb[1], "R6", err, q_nb[1]);
        chk(int'(bin) == q_pop[1], "R8", int'(bin), q_pop[1]);
      end
    end
    q_v[1] = q_v[0]; q_cl[1] = q_cl[0]; q_ref[1] = q_ref[0];
    q_nb[1] = q_nb[0]; q_pop[1] = q_pop[0]; q_tap[1] = q_tap[0]; q_tag[1] = q_tag[0];
    q_v[0] = 1'b1; q_cl[0] = clean; q_ref[0] = ref_v;
    q_nb[0] = $countones(d ^ therm_of(ref_v));
    q_pop[0] = $countones(d); q_tap[0] = tap_cnt(d); q_tag[0] = tag;
    therm = d;
  endtask

  initial begin
    logic [62:0] d;
    int v;
    int nf;
    void'($urandom(32'd7135));
    q_v[0] = 1'b0; q_v[1] = 1'b0;

    repeat (3) @(negedge clk);
    chk(bin == 6'd0, "R2", int'(bin), 0);
    rst_n = 1'b1;

    // R1: exact latency
    @(negedge clk);
    therm = therm_of(37);
    @(negedge clk);
    therm = '0;
    chk(bin == 6'd0, "R1", int'(bin), 0);
    @(negedge clk);
    chk(bin == 6'd37, "R1", int'(bin), 37);
    @(negedge clk);

    // R3/R4/R7: every clean code back to back
    for (int k = 0; k < 64; k++) drive(therm_of(k), k, 1'b1, "R3");
    for (int k = 63; k >= 0; k -= 9) drive(therm_of(k), k, 1'b1, "R7");

    // R5 corners
    drive('0, 0, 1'b1, "R5");
    drive('1, 63, 1'b1, "R5");
    drive('0, 0, 1'b1, "R5");

    // R6/R8: random bubbles
    for (int k = 0; k < 400; k++) begin
      v = $urandom_range(63, 0);
      d = therm_of(v);
      nf = $urandom_range(4, 1);
      for (int j = 0; j < nf; j++) begin
        int idx;
        idx = $urandom_range(62, 0);
        d[idx] = ~d[idx];
      end
      drive(d, v, 1'b0, "R6");
    end
    drive('0, 0, 1'b1, "R3");
    drive('0, 0, 1'b1, "R3");
    drive('0, 0, 1'b1, "R3");

    // R2: asynchronous clear mid-run
    @(negedge clk);
    therm = '1;
    @(negedge clk);
    @(negedge clk);
    chk(bin == 6'd63, "R5", int'(bin), 63);
    #3 rst_n = 1'b0;
    #1 chk(bin == 6'd0, "R2", int'(bin), 0);
    @(negedge clk);
    chk(bin == 6'd0, "R2", int'(bin), 0);
    rst_n = 1'b1;
    therm = '0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule